// File: doc/BRIEF.md
# Chopper Polarity Sequencer

The block decides which way an input chopping switch is connected during each cycle of a measurement multiplexer. An accumulation interval is made of a fixed number of multiplexer cycles. The first cycle of each interval is the alternate cycle, and the block flags it on its own output. The block counts cycle boundaries, reports the index of the current cycle, and gives a one-cycle transfer-done pulse when a new interval starts.

Firmware picks the polarity with a 2-bit mode value. Any write goes into a shadow register and is used only at the next cycle boundary, so the value is in force for the whole of the following multiplexer cycle. A forced mode applies to one cycle only. After that cycle the block returns to automatic toggling, in which the polarity inverts at every boundary. Firmware can force positive polarity on the alternate cycle of one interval and reversed polarity on the alternate cycle of the next. The alternate cycles then alternate in polarity whatever the interval length.

Top module: `chop_seq`

## Requirements
- R1: After reset, pol_o is 0 (positive), cyc_idx_o is 0, alt_o is 1 and xfer_o is 0. Any mode write still pending is discarded, so the first boundary after reset toggles the polarity.
- R2: Mode code 2'b11 selects automatic toggle: at a boundary (cyc_end_i high at a clock edge) pol_o inverts.
- R3: Mode code 2'b00 behaves exactly like 2'b11.
- R4: Mode code 2'b01 makes the next cycle positive (pol_o=0), and code 2'b10 makes it reversed (pol_o=1). pol_o changes only at a boundary.
- R5: A write (mode_wr_i high) has no visible effect until the next boundary. A write made in the same clock as a boundary is held for the boundary after it. A later write made before the boundary replaces an earlier pending one.
- R6: A written mode applies to one cycle only. With no new write, the following boundary toggles again.
- R7: cyc_idx_o advances by one at each boundary and wraps from N_CYC-1 to 0. alt_o is high exactly when cyc_idx_o is 0.
- R8: xfer_o is high for one clock, in the clock in which cyc_idx_o has just wrapped to 0. It is low at all other times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cyc_end_i | input | 1 | Multiplexer cycle boundary pulse |
| mode_wr_i | input | 1 | Mode write strobe |
| mode_i | input | 2 | Mode code: 11/00 auto, 01 positive, 10 reversed |
| pol_o | output | 1 | Chop polarity, 0 positive, 1 reversed |
| alt_o | output | 1 | Current cycle is the alternate cycle |
| cyc_idx_o | output | $clog2(N_CYC) | Index of the current cycle within the interval |
| xfer_o | output | 1 | Interval start pulse |

## Verification
A shadow register that fails to clear would show at the second boundary after a forced write: pol_o repeats the forced value instead of toggling. A write that leaks into the current cycle would change pol_o in the clock after the write, with no boundary in between. A cycle counter that is off by one would move alt_o and xfer_o by a whole multiplexer cycle, and this shows at the first interval wrap after reset.

// File: rtl/chop_pkg.sv
package chop_pkg;
  typedef enum logic [1:0] {
    MODE_AUTO0 = 2'b00,
    MODE_POS   = 2'b01,
    MODE_REV   = 2'b10,
    MODE_AUTO  = 2'b11
  } chop_mode_e;
endpackage

// File: rtl/chop_mode_shadow.sv
module chop_mode_shadow
  import chop_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       bnd_i,
  input  logic       wr_i,
  input  logic [1:0] mode_i,
  output logic       vld_o,
  output chop_mode_e mode_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_o  <= 1'b0;
      mode_o <= MODE_AUTO;
    end else if (wr_i) begin
      // a write always lands; on a boundary it waits for the next one
      vld_o  <= 1'b1;
      mode_o <= chop_mode_e'(mode_i);
    end else if (bnd_i) begin
      vld_o  <= 1'b0;
    end
  end

  AST_SHADOW_ONE_SHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bnd_i && !wr_i |=> !vld_o); // R6
  AST_WRITE_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |=> vld_o && mode_o == $past(mode_i)); // R5
endmodule

// File: rtl/chop_cycle_cnt.sv
module chop_cycle_cnt #(
  parameter int N_CYC = 4,
  localparam int IDXW = $clog2(N_CYC)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            bnd_i,
  output logic [IDXW-1:0] idx_o,
  output logic            xfer_o
);
  localparam logic [IDXW-1:0] LAST = IDXW'(N_CYC - 1);
  logic last;
  assign last = (idx_o == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_o  <= '0;
      xfer_o <= 1'b0;
    end else begin
      xfer_o <= bnd_i && last;
      if (bnd_i) idx_o <= last ? '0 : idx_o + 1'b1;
    end
  end

  AST_IDX_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idx_o <= LAST); // R7
  AST_IDX_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bnd_i |=> $stable(idx_o)); // R7
  AST_XFER_AT_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xfer_o |-> idx_o == '0); // R8
  AST_XFER_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xfer_o |=> !xfer_o); // R8
endmodule

// File: rtl/chop_pol_gen.sv
module chop_pol_gen
  import chop_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       bnd_i,
  input  logic       vld_i,
  input  chop_mode_e mode_i,
  output logic       pol_o
);
  logic force_pos, force_rev;
  assign force_pos = vld_i && (mode_i == MODE_POS);
  assign force_rev = vld_i && (mode_i == MODE_REV);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        pol_o <= 1'b0;
    else if (bnd_i) begin
      if (force_pos)      pol_o <= 1'b0;
      else if (force_rev) pol_o <= 1'b1;
      else                pol_o <= ~pol_o;
    end
  end

  AST_POL_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bnd_i |=> $stable(pol_o)); // R4
  AST_AUTO_TOGGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bnd_i && !vld_i |=> pol_o != $past(pol_o)); // R2
  AST_FORCE_POS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bnd_i && force_pos |=> !pol_o); // R4
  AST_FORCE_REV: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bnd_i && force_rev |=> pol_o); // R4
endmodule

// File: rtl/chop_seq.sv
module chop_seq
  import chop_pkg::*;
#(
  parameter int N_CYC = 4,
  localparam int IDXW = $clog2(N_CYC)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            cyc_end_i,
  input  logic            mode_wr_i,
  input  logic [1:0]      mode_i,
  output logic            pol_o,
  output logic            alt_o,
  output logic [IDXW-1:0] cyc_idx_o,
  output logic            xfer_o
);
  logic       sh_vld;
  chop_mode_e sh_mode;

  chop_mode_shadow u_shadow (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .bnd_i  (cyc_end_i),
    .wr_i   (mode_wr_i),
    .mode_i (mode_i),
    .vld_o  (sh_vld),
    .mode_o (sh_mode)
  );

  chop_cycle_cnt #(.N_CYC(N_CYC)) u_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .bnd_i  (cyc_end_i),
    .idx_o  (cyc_idx_o),
    .xfer_o (xfer_o)
  );

  chop_pol_gen u_pol (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .bnd_i  (cyc_end_i),
    .vld_i  (sh_vld),
    .mode_i (sh_mode),
    .pol_o  (pol_o)
  );

  assign alt_o = (cyc_idx_o == '0);

  AST_WRITE_NO_EFFECT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_wr_i && !cyc_end_i |=> $stable(pol_o)); // R5
  AST_ALT_AFTER_XFER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xfer_o |-> alt_o); // R7
endmodule

// File: tb/chop_seq_tb_top.sv
module chop_seq_tb_top;
  localparam int N_CYC = 4;
  localparam int NV = 22;
  // {wr, mode[1:0], end, exp_pol, exp_alt, exp_xfer, exp_idx[1:0]}
  localparam logic [8:0] VEC [NV] = '{
    9'b0_00_1_1_0_0_01, 9'b0_00_1_0_0_0_10, 9'b0_00_1_1_0_0_11, 9'b0_00_1_0_1_1_00,
    9'b1_10_0_0_1_0_00, 9'b0_00_1_1_0_0_01, 9'b0_00_1_0_0_0_10, 9'b1_01_1_1_0_0_11,
    9'b0_00_1_0_1_1_00, 9'b0_00_1_1_0_0_01, 9'b1_01_0_1_0_0_01, 9'b1_10_0_1_0_0_01,
    9'b0_00_1_1_0_0_10, 9'b1_00_0_1_0_0_10, 9'b0_00_1_0_0_0_11, 9'b1_11_0_0_0_0_11,
    9'b0_00_1_1_1_1_00, 9'b0_00_1_0_0_0_01, 9'b0_00_1_1_0_0_10, 9'b1_01_0_1_0_0_10,
    9'b0_00_1_0_0_0_11, 9'b0_00_1_1_1_1_00
  };
  localparam string TAG [NV] = '{
    "R2", "R2", "R2", "R2", "R5", "R4", "R6", "R5", "R4", "R6", "R5",
    "R5", "R4", "R3", "R3", "R2", "R2", "R2", "R2", "R5", "R4", "R6"
  };

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       cyc_end_i = 1'b0, mode_wr_i = 1'b0;
  logic [1:0] mode_i = 2'b00;
  logic       pol_o, alt_o, xfer_o;
  logic [1:0] cyc_idx_o;
  int n_chk = 0, n_bad = 0;

  always #2 clk_i = ~clk_i;

  chop_seq #(.N_CYC(N_CYC)) dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .cyc_end_i(cyc_end_i), .mode_wr_i(mode_wr_i),
    .mode_i(mode_i), .pol_o(pol_o), .alt_o(alt_o), .cyc_idx_o(cyc_idx_o), .xfer_o(xfer_o)
  );

  task automatic chk(input string tag, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic step(input logic wr, input logic [1:0] md, input logic e);
    @(negedge clk_i);
    mode_wr_i = wr; mode_i = md; cyc_end_i = e;
    @(posedge clk_i); #1;
    mode_wr_i = 1'b0; cyc_end_i = 1'b0;
  endtask

  task automatic chk_all(input string tag, input logic p, input logic a, input logic x,
                         input logic [1:0] ix);
    chk(tag, "pol_o", int'(p ? 1 : 0) == 0 ? int'(pol_o) : int'(pol_o), int'(p));
    chk("R7", "alt_o", int'(alt_o), int'(a));
    chk("R7", "cyc_idx_o", int'(cyc_idx_o), int'(ix));
    chk("R8", "xfer_o", int'(xfer_o), int'(x));
  endtask

  initial begin
    #(4 * 200000);
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk_i);
    #1;
    chk_all("R1", 1'b0, 1'b1, 1'b0, 2'd0);  // R1 reset state
    @(negedge clk_i) rst_ni = 1'b1;
    for (int i = 0; i < NV; i++) begin
      step(VEC[i][8], VEC[i][7:6], VEC[i][5]);
      chk_all(TAG[i], VEC[i][4], VEC[i][3], VEC[i][2], VEC[i][1:0]);
    end
    // R4: polarity holds through idle clocks without a boundary
    repeat (5) step(1'b0, 2'b00, 1'b0);
    chk("R4", "pol_o idle", int'(pol_o), 1);
    // R1: reset discards a pending forced write
    step(1'b1, 2'b01, 1'b0);
    @(negedge clk_i) rst_ni = 1'b0;
    #1;
    chk_all("R1", 1'b0, 1'b1, 1'b0, 2'd0);
    @(negedge clk_i) rst_ni = 1'b1;
    step(1'b0, 2'b00, 1'b1);
    chk("R1", "pol_o after reset boundary", int'(pol_o), 1);
    chk("R7", "cyc_idx_o after reset boundary", int'(cyc_idx_o), 1);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule